// File: doc/BRIEF.md
# Interrupt Pin Mapping Router

This block takes a vector of pending interrupt sources and delivers each one to a set of processor targets. On every target that a source reaches, the source lands on one of three destinations: one of six ordinary interrupt pins, the non-maskable interrupt line, or a secondary yield line. Each source has two pieces of routing state. The first is a route word that holds the destination flags and a pin index. The second is a target bitmap that names the targets which receive the source. Software programs both through a simple register write port and can read them back through a combinational read port.

Each target receives six pin levels, an NMI level and a yield level. Each level is the OR of all pending sources routed there. For a processor that runs with an external interrupt controller, each target also gets a vector number: the index of its highest-numbered active pin plus one, or zero when no pin on that target is active. All routing state clears on reset, so no source reaches any target until software programs it.

Top module: `irq_route`

## Requirements
- R1: After reset all route words and target bitmaps read as zero, and every pin, NMI, yield and vector output is zero whatever the pending inputs are.
- R2: Route word layout: bit 31 requests an ordinary pin, bit 30 requests NMI, bit 29 requests the yield line, and bits 5:0 hold the pin index. A read returns only these bits and shows all other bits as zero.
- R3: The route word of source s sits at byte address 4*s from address 0. Misaligned addresses and addresses past the last source are neither stored nor read, and they read as zero.
- R4: The target bitmap of source s starts at byte address 0x400 + 32*s. Target t sits in word t/32 of that block (word address + 4*(t/32)), at bit t%32. Words beyond the configured number of targets read as zero.
- R5: Pin p of target t is high when at least one pending source is in pin mode, has pin index p, and has bit t set in its target bitmap.
- R6: When several destination flags are set, NMI wins over the ordinary pin, and the ordinary pin wins over the yield line. The source drives only the winning destination.
- R7: The NMI output and the yield output of a target are each the OR of the pending sources that are routed to that destination and that select that target.
- R8: A source in pin mode whose pin index is 6 or more drives nothing.
- R9: The vector output of each target (3 bits) equals the highest active pin index plus one, and equals 0 when none of its pins is active.
- R10: A source that is not pending, or whose bitmap bit for a target is clear, has no effect on that target's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_SRC | Pending level of each source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | ADDR_W | Register read byte address |
| rd_data_o | output | 32 | Register read data (combinational) |
| pin_o | output | NUM_TGT*6 | Pin levels, target t at bits 6t+5:6t |
| nmi_o | output | NUM_TGT | NMI level per target |
| yield_o | output | NUM_TGT | Yield-line level per target |
| vec_o | output | NUM_TGT*3 | Vector number per target, target t at bits 3t+2:3t |

## Verification
The hardest cases to reach from the ports are conflicting route words, where more than one destination flag is set, and out-of-range pin indexes. The normal driver never produces them, so the stimulus writes raw route words that combine the flags and that put indexes above the last pin. The vector encoder has to see several pins active on one target at once. Directed cases reach this by routing two pending sources to different pins of the same target and then dropping the higher one. A vector table runs each routing case against different target bitmaps, which shows that sources stay away from unselected targets.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int PIN_COUNT = 6;
    localparam int PIN_IDX_W = 6;
    localparam int VEC_W     = $clog2(PIN_COUNT + 1);
    localparam int DATA_W    = 32;

    localparam int FLAG_PIN_BIT   = 31;
    localparam int FLAG_NMI_BIT   = 30;
    localparam int FLAG_YIELD_BIT = 29;

    typedef struct packed {
        logic                 to_pin;
        logic                 to_nmi;
        logic                 to_yield;
        logic [PIN_IDX_W-1:0] pin;
    } route_word_t;

    typedef enum logic [1:0] {
        DEST_NONE,
        DEST_PIN,
        DEST_NMI,
        DEST_YIELD
    } dest_e;

    function automatic route_word_t unpack_route(input logic [DATA_W-1:0] w);
        route_word_t r;
        r.to_pin   = w[FLAG_PIN_BIT];
        r.to_nmi   = w[FLAG_NMI_BIT];
        r.to_yield = w[FLAG_YIELD_BIT];
        r.pin      = w[PIN_IDX_W-1:0];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_route(input route_word_t r);
        logic [DATA_W-1:0] w;
        w                  = '0;
        w[FLAG_PIN_BIT]    = r.to_pin;
        w[FLAG_NMI_BIT]    = r.to_nmi;
        w[FLAG_YIELD_BIT]  = r.to_yield;
        w[PIN_IDX_W-1:0]   = r.pin;
        return w;
    endfunction

    // NMI beats ordinary pin, ordinary pin beats yield
    function automatic dest_e resolve_dest(input route_word_t r);
        if (r.to_nmi)                                return DEST_NMI;
        if (r.to_pin && (32'(r.pin) < PIN_COUNT))    return DEST_PIN;
        if (r.to_pin)                                return DEST_NONE;
        if (r.to_yield)                              return DEST_YIELD;
        return DEST_NONE;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_TGT = 4,
    parameter int ADDR_W  = 12
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output route_word_t [NUM_SRC-1:0]         route_o,
    output logic [NUM_SRC-1:0][NUM_TGT-1:0]   tmask_o
);

    localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int WRD_W     = 3;
    localparam int TGT_WORDS = (NUM_TGT + 31) / 32;
    localparam int MAP_END   = 4 * NUM_SRC;
    localparam int BM_BASE   = 'h400;
    localparam int BM_END    = BM_BASE + 32 * NUM_SRC;

    typedef struct packed {
        logic             map_hit;
        logic             bm_hit;
        logic [SRC_W-1:0] src;
        logic [WRD_W-1:0] wrd;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        int   ai;
        int   off;
        d  = '0;
        ai = 32'(a);
        if (a[1:0] == 2'b00) begin
            if (ai < MAP_END) begin
                d.map_hit = 1'b1;
                d.src     = SRC_W'(ai >> 2);
            end else if (ai >= BM_BASE && ai < BM_END) begin
                off = ai - BM_BASE;
                if (((off >> 2) & 7) < TGT_WORDS) begin
                    d.bm_hit = 1'b1;
                    d.src    = SRC_W'(off >> 5);
                    d.wrd    = WRD_W'((off >> 2) & 7);
                end
            end
        end
        return d;
    endfunction

    route_word_t [NUM_SRC-1:0]       route_q;
    logic [NUM_SRC-1:0][NUM_TGT-1:0] tmask_q;
    dec_t                            wdec;
    dec_t                            rdec;

    assign wdec = decode(wr_addr);
    assign rdec = decode(rd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
            tmask_q <= '0;
        end else if (wr_en) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (wdec.map_hit && 32'(wdec.src) == s)
                    route_q[s] <= unpack_route(wr_data);
                for (int t = 0; t < NUM_TGT; t++) begin
                    if (wdec.bm_hit && 32'(wdec.src) == s && 32'(wdec.wrd) == t / 32)
                        tmask_q[s][t] <= wr_data[t % 32];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rdec.map_hit) begin
            rd_data = pack_route(route_q[rdec.src]);
        end else if (rdec.bm_hit) begin
            for (int t = 0; t < NUM_TGT; t++) begin
                if (32'(rdec.wrd) == t / 32)
                    rd_data[t % 32] = tmask_q[rdec.src][t];
            end
        end
    end

    assign route_o = route_q;
    assign tmask_o = tmask_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (route_q == '0 && tmask_q == '0));

    // R3
    map_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdec.map_hit) |=>
            (pack_route(route_q[$past(wdec.src)]) == pack_route(unpack_route($past(wr_data)))));

endmodule

// File: rtl/irq_route_vec.sv
module irq_route_vec
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PIN_COUNT-1:0] pin_i,
    output logic [VEC_W-1:0]     vec_o
);

    always_comb begin
        vec_o = '0;
        for (int p = 0; p < PIN_COUNT; p++) begin
            if (pin_i[p])
                vec_o = VEC_W'(p + 1);
        end
    end

    // R9
    vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_i == '0) |-> (vec_o == '0));

    // R9
    vec_top_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_o != '0) |-> (pin_i[vec_o - 1'b1] && ((pin_i >> vec_o) == '0)));

endmodule

// File: rtl/irq_route_target.sv
module irq_route_target
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        pend_i,
    input  logic [NUM_SRC-1:0]        sel_i,
    input  route_word_t [NUM_SRC-1:0] route_i,
    output logic [PIN_COUNT-1:0]      pin_o,
    output logic                      nmi_o,
    output logic                      yield_o,
    output logic [VEC_W-1:0]          vec_o
);

    always_comb begin
        pin_o   = '0;
        nmi_o   = 1'b0;
        yield_o = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (pend_i[s] && sel_i[s]) begin
                unique case (resolve_dest(route_i[s]))
                    DEST_NMI:   nmi_o   = 1'b1;
                    DEST_YIELD: yield_o = 1'b1;
                    DEST_PIN: begin
                        for (int p = 0; p < PIN_COUNT; p++)
                            if (32'(route_i[s].pin) == p) pin_o[p] = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    irq_route_vec u_vec (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_o),
        .vec_o (vec_o)
    );

    // R10
    no_select_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_i & sel_i) == '0) |-> (pin_o == '0 && !nmi_o && !yield_o));

endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_TGT = 4,
    parameter int ADDR_W  = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_SRC-1:0]           pend_i,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    input  logic [ADDR_W-1:0]            rd_addr_i,
    output logic [DATA_W-1:0]            rd_data_o,
    output logic [NUM_TGT*PIN_COUNT-1:0] pin_o,
    output logic [NUM_TGT-1:0]           nmi_o,
    output logic [NUM_TGT-1:0]           yield_o,
    output logic [NUM_TGT*VEC_W-1:0]     vec_o
);

    route_word_t [NUM_SRC-1:0]       route;
    logic [NUM_SRC-1:0][NUM_TGT-1:0] tmask;

    irq_route_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_TGT (NUM_TGT),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .rd_addr (rd_addr_i),
        .rd_data (rd_data_o),
        .route_o (route),
        .tmask_o (tmask)
    );

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        logic [NUM_SRC-1:0] sel;
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
            assign sel[s] = tmask[s][t];
        end

        irq_route_target #(
            .NUM_SRC (NUM_SRC)
        ) u_target (
            .clk     (clk),
            .rst     (rst),
            .pend_i  (pend_i),
            .sel_i   (sel),
            .route_i (route),
            .pin_o   (pin_o[t*PIN_COUNT +: PIN_COUNT]),
            .nmi_o   (nmi_o[t]),
            .yield_o (yield_o[t]),
            .vec_o   (vec_o[t*VEC_W +: VEC_W])
        );
    end

    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_i == '0) |-> (pin_o == '0 && nmi_o == '0 && yield_o == '0 && vec_o == '0));

    // R6
    single_dest_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(pend_i) == 1 && $countones(tmask[0]) != 0 && pend_i[0])
            |-> $onehot0({|pin_o[PIN_COUNT-1:0], nmi_o[0], yield_o[0]}));

endmodule

// File: tb/irq_route_tb.sv
`timescale 1ns/1ps
module irq_route_tb;

    localparam int NS = 8;
    localparam int NT = 4;
    localparam int AW = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NS-1:0]  pend = '0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [AW-1:0]  rd_addr = '0;
    logic [31:0]    rd_data;
    logic [NT*6-1:0] pin;
    logic [NT-1:0]  nmi;
    logic [NT-1:0]  yld;
    logic [NT*3-1:0] vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_route #(.NUM_SRC(NS), .NUM_TGT(NT), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .pend_i    (pend),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .pin_o     (pin),
        .nmi_o     (nmi),
        .yield_o   (yld),
        .vec_o     (vec)
    );

    typedef struct packed {
        logic [2:0]  src;
        logic [31:0] word;
        logic [3:0]  bmp;
        logic [7:0]  pend;
        logic [5:0]  pin;
        logic        nmi;
        logic        yld;
        logic [2:0]  vec;
    } case_t;

    localparam int NCASE = 10;
    localparam case_t TBL [NCASE] = '{
        '{3'd0, 32'h8000_0002, 4'b0001, 8'h01, 6'b000100, 1'b0, 1'b0, 3'd3},
        '{3'd3, 32'h8000_0005, 4'b1010, 8'h08, 6'b100000, 1'b0, 1'b0, 3'd6},
        '{3'd5, 32'h4000_0001, 4'b0011, 8'h20, 6'b000000, 1'b1, 1'b0, 3'd0},
        '{3'd7, 32'h2000_0000, 4'b1111, 8'h80, 6'b000000, 1'b0, 1'b1, 3'd0},
        '{3'd2, 32'hC000_0003, 4'b0100, 8'h04, 6'b000000, 1'b1, 1'b0, 3'd0},
        '{3'd4, 32'hA000_0001, 4'b0001, 8'h10, 6'b000010, 1'b0, 1'b0, 3'd2},
        '{3'd1, 32'h8000_0000, 4'b1000, 8'h00, 6'b000000, 1'b0, 1'b0, 3'd0},
        '{3'd6, 32'h8000_0007, 4'b1111, 8'h40, 6'b000000, 1'b0, 1'b0, 3'd0},
        '{3'd0, 32'h8000_0000, 4'b0000, 8'h01, 6'b000000, 1'b0, 1'b0, 3'd0},
        '{3'd6, 32'h6000_0004, 4'b0010, 8'h40, 6'b000000, 1'b1, 1'b0, 3'd0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic clear_all();
        for (int s = 0; s < NS; s++) begin
            reg_write(AW'(4 * s), 32'h0);
            reg_write(AW'('h400 + 32 * s), 32'h0);
        end
    endtask

    task automatic check_outs(input string req, input logic [NT*6-1:0] ep,
                              input logic [NT-1:0] en, input logic [NT-1:0] ey,
                              input logic [NT*3-1:0] ev);
        #1;
        check({req, " pins"},   64'(pin), 64'(ep));
        check({req, " nmi"},    64'(nmi), 64'(en));
        check({req, " yield"},  64'(yld), 64'(ey));
        check({req, " vector"}, 64'(vec), 64'(ev));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [NT*6-1:0] ep;
        logic [NT-1:0]   en;
        logic [NT-1:0]   ey;
        logic [NT*3-1:0] ev;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state, all sources pending but nothing routed
        pend = '1;
        check_outs("R1 reset outputs", '0, '0, '0, '0);
        reg_read(12'h000, rv); check("R1 route word 0", 64'(rv), 64'h0);
        reg_read(12'h41C + 12'h004, rv); check("R1 bitmap src1", 64'(rv), 64'h0);
        pend = '0;

        // R5 R6 R7 R8 R10: table walk
        for (int i = 0; i < NCASE; i++) begin
            clear_all();
            reg_write(AW'(4 * TBL[i].src), TBL[i].word);
            reg_write(AW'('h400 + 32 * TBL[i].src), 32'(TBL[i].bmp));
            pend = TBL[i].pend;
            for (int t = 0; t < NT; t++) begin
                ep[t*6 +: 6] = TBL[i].bmp[t] ? TBL[i].pin : 6'b0;
                en[t]        = TBL[i].bmp[t] & TBL[i].nmi;
                ey[t]        = TBL[i].bmp[t] & TBL[i].yld;
                ev[t*3 +: 3] = TBL[i].bmp[t] ? TBL[i].vec : 3'd0;
            end
            check_outs($sformatf("R5 R6 R7 R8 R10 table entry %0d", i), ep, en, ey, ev);
            pend = '0;
        end

        // R2: readback keeps only the defined bits
        reg_write(12'h008, 32'hFFFF_FFFF);
        reg_read(12'h008, rv); check("R2 route word masking", 64'(rv), 64'hE000_003F);

        // R4: bitmap readback and undecoded second word
        reg_write(12'h460, 32'hFFFF_FFFF);
        reg_read(12'h460, rv); check("R4 bitmap src3", 64'(rv), 64'h0000_000F);
        reg_write(12'h464, 32'hFFFF_FFFF);
        reg_read(12'h464, rv); check("R4 bitmap word beyond targets", 64'(rv), 64'h0);

        // R3: misaligned and past-end writes are ignored
        clear_all();
        reg_write(12'h001, 32'h8000_0001);
        reg_write(12'h020, 32'h8000_0001);
        reg_read(12'h000, rv); check("R3 misaligned write ignored", 64'(rv), 64'h0);
        reg_read(12'h020, rv); check("R3 past-end read zero", 64'(rv), 64'h0);
        reg_write(12'h01C, 32'h8000_0003);
        reg_read(12'h01C, rv); check("R3 last source word", 64'(rv), 64'h8000_0003);

        // R9: two pins on one target, then the higher one drops
        clear_all();
        reg_write(12'h000, 32'h8000_0001);
        reg_write(12'h400, 32'h1);
        reg_write(12'h004, 32'h8000_0004);
        reg_write(12'h420, 32'h1);
        pend = 8'h03;
        check_outs("R9 two pins", 24'b010010, '0, '0, 12'd5);
        pend = 8'h01;
        check_outs("R9 higher pin dropped", 24'b000010, '0, '0, 12'd2);
        pend = 8'h02;
        check_outs("R9 R5 single high pin", 24'b010000, '0, '0, 12'd5);

        // R1: reset in mid-operation clears routing
        pend = '1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_outs("R1 reset mid-run", '0, '0, '0, '0);
        reg_read(12'h004, rv); check("R1 route cleared", 64'(rv), 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule